// File: doc/BRIEF.md
# Predicate Bit Packer Sequencer

This block turns a run of condition-field tests into packed predicate bits inside integer registers. After a start strobe it steps through vector elements 0 to VL-1 at one element per clock. For each element it reads one 4-bit condition field, reduces that field to a single bit through a mask/map test, and writes the bit into the integer register file. The condition field is either stepped from a base index or held at the base index when the source is scalar.

Results are packed by bits, not by registers. A 2-bit packing code sets how many results share one destination register: 1, 2, 4 or 8. Element i then goes to register base + i/k, at bit i mod k. A scalar destination takes the results as consecutive bits of one register. In that case a map-reduce flag decides whether the loop goes past the first element. Each register-file write carries a per-bit write mask, so the block needs no read port on the integer file.

Top module: `pred_bit_packer`

## Requirements
- R1: With a vector source, element i reads condition field cf_base+i. With a scalar source, every element reads cf_base.
- R2: Let n = (NOT fmap XOR field) AND fmsk. With m_any=1 the element result is 1 when n is non-zero. With m_any=0 the result is 1 when n equals fmsk.
- R3: With a vector destination, pack_code 00/01/10/11 packs k = 1/2/4/8 results per register. Element i is written to register rf_base + i/k, at LSB bit position i mod k.
- R4: With a vector destination, the first element of each register writes with an all-ones mask. Every bit above the packed result bits therefore ends up zero. Later elements write only their own bit. wr_data never has a bit set outside wr_mask.
- R5: With a scalar destination, element i writes only bit i of register rf_base, with a one-hot mask.
- R6: With a scalar destination and mapreduce=0, exactly one element is processed when VL is at least 1. With mapreduce=1, the loop runs through VL.
- R7: With a scalar destination and VL above 64, at most 64 elements are written and err is high in the done cycle. err is never high outside a done cycle.
- R8: Writes occur on consecutive cycles, one element per cycle, starting the cycle after start is accepted. done is high for exactly one cycle, the cycle after the last write.
- R9: With zero elements to process, done is high in the cycle after start and no write occurs.
- R10: A start pulse while the block is busy is ignored. The sequence in progress is unchanged, and no new sequence follows it.
- R11: Condition-field and register indices wrap modulo 2^CFI_W and 2^RFI_W.
- R12: After reset, wr_en, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| vl | input | VL_W | Number of elements |
| src_vec | input | 1 | 1: step condition field per element |
| dst_vec | input | 1 | 1: packed vector destination, 0: scalar destination |
| cf_base | input | CFI_W | First condition-field index |
| rf_base | input | RFI_W | First destination register index |
| m_any | input | 1 | 1: any-bit test, 0: all-bits test |
| fmsk | input | 4 | Field bit mask |
| fmap | input | 4 | Field bit polarity map |
| pack_code | input | 2 | Results per register: 00=1, 01=2, 10=4, 11=8 |
| mapreduce | input | 1 | Continue past element 0 on scalar destination |
| cf_rd_idx | output | CFI_W | Condition-field read index |
| cf_rd_data | input | 4 | Condition-field read data (same cycle) |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | RFI_W | Register-file write index |
| wr_mask | output | XLEN | Per-bit write enable |
| wr_data | output | XLEN | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Scalar destination with VL above 64, with done |

## Verification
The bench uses the default parameters: VL_W=8, XLEN=64, and 7-bit field and register indices. With an 8-bit VL, a scalar-destination run of 70 elements is possible, which exercises the 64-bit clipping and the error flag. With 7-bit indices, bases near 127 make both the field walk and the register walk wrap within a short run. The register file starts with a non-zero pattern, so cleared upper bits and preserved neighbours both show in the final register contents.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    typedef enum logic [1:0] {
        PACK_1 = 2'b00,
        PACK_2 = 2'b01,
        PACK_4 = 2'b10,
        PACK_8 = 2'b11
    } pack_code_e;

    typedef struct packed {
        logic       m_any;
        logic [3:0] fmsk;
        logic [3:0] fmap;
    } test_cfg_t;

    // Reduce one 4-bit condition field to a single predicate bit.
    function automatic logic field_test(test_cfg_t cfg, logic [3:0] fld);
        logic [3:0] sel;
        sel = (~cfg.fmap ^ fld) & cfg.fmsk;
        return cfg.m_any ? (sel != 4'b0000) : (sel == cfg.fmsk);
    endfunction

endpackage

// File: rtl/pbp_elem_test.sv
module pbp_elem_test
    import pbp_pkg::*;
(
    input  test_cfg_t  cfg,
    input  logic [3:0] fld,
    output logic       hit
);
    always_comb hit = field_test(cfg, fld);
endmodule

// File: rtl/pbp_seq.sv
module pbp_seq #(
    parameter int VL_W = 8,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VL_W-1:0] vl,
    input  logic            dst_vec,
    input  logic            mapreduce,
    output logic            accept,
    output logic            busy,
    output logic [VL_W-1:0] elem,
    output logic            done,
    output logic            err
);
    localparam logic [VL_W:0] CAP = (VL_W+1)'(XLEN);

    logic [VL_W-1:0] total;
    logic [VL_W-1:0] last_q;
    logic            over;
    logic            err_q;

    always_comb begin
        over = !dst_vec && ({1'b0, vl} > CAP);
        if (dst_vec)        total = vl;
        else if (!mapreduce) total = (vl != '0) ? VL_W'(1) : '0;
        else if (over)      total = CAP[VL_W-1:0];
        else                total = vl;
    end

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            elem   <= '0;
            last_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (busy) begin
                if (elem == last_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    err  <= err_q;
                end else begin
                    elem <= elem + 1'b1;
                end
            end else if (start) begin
                if (total == '0) begin
                    done <= 1'b1;
                    err  <= over;
                end else begin
                    busy   <= 1'b1;
                    elem   <= '0;
                    last_q <= total - 1'b1;
                    err_q  <= over;
                end
            end
        end
    end

    assert_elem_step_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (elem == $past(elem) + 1'b1));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done);

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

endmodule

// File: rtl/pbp_pack.sv
module pbp_pack #(
    parameter int VL_W  = 8,
    parameter int XLEN  = 64,
    parameter int RFI_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [VL_W-1:0]  elem,
    input  logic             dst_vec,
    input  logic [1:0]       code,
    input  logic [RFI_W-1:0] rf_base,
    input  logic             result,
    output logic             wr_en,
    output logic [RFI_W-1:0] wr_idx,
    output logic [XLEN-1:0]  wr_mask,
    output logic [XLEN-1:0]  wr_data
);
    localparam int BIT_W = $clog2(XLEN);

    logic [VL_W-1:0]  roff;
    logic [BIT_W-1:0] pos;
    logic [XLEN-1:0]  onebit;

    always_comb begin
        if (dst_vec) begin
            roff = elem >> code;
            pos  = BIT_W'(elem & ((VL_W'(1) << code) - VL_W'(1)));
        end else begin
            roff = '0;
            pos  = elem[BIT_W-1:0];
        end
        onebit  = XLEN'(1) << pos;
        wr_mask = (dst_vec && pos == '0) ? '1 : onebit;
        wr_data = result ? onebit : '0;
        wr_idx  = rf_base + RFI_W'(roff);
        wr_en   = valid;
    end

    assert_data_in_mask_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_data & ~wr_mask) == '0));

    assert_scalar_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dst_vec) |-> ($countones(wr_mask) == 1));

endmodule

// File: rtl/pred_bit_packer.sv
module pred_bit_packer
    import pbp_pkg::*;
#(
    parameter int VL_W  = 8,
    parameter int XLEN  = 64,
    parameter int CFI_W = 7,
    parameter int RFI_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VL_W-1:0]  vl,
    input  logic             src_vec,
    input  logic             dst_vec,
    input  logic [CFI_W-1:0] cf_base,
    input  logic [RFI_W-1:0] rf_base,
    input  logic             m_any,
    input  logic [3:0]       fmsk,
    input  logic [3:0]       fmap,
    input  logic [1:0]       pack_code,
    input  logic             mapreduce,
    output logic [CFI_W-1:0] cf_rd_idx,
    input  logic [3:0]       cf_rd_data,
    output logic             wr_en,
    output logic [RFI_W-1:0] wr_idx,
    output logic [XLEN-1:0]  wr_mask,
    output logic [XLEN-1:0]  wr_data,
    output logic             done,
    output logic             err
);
    logic             accept;
    logic             busy;
    logic [VL_W-1:0]  elem;
    logic             hit;

    test_cfg_t        cfg_q;
    pack_code_e       code_q;
    logic [CFI_W-1:0] cf_base_q;
    logic [RFI_W-1:0] rf_base_q;
    logic             src_vec_q;
    logic             dst_vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            code_q    <= PACK_1;
            cf_base_q <= '0;
            rf_base_q <= '0;
            src_vec_q <= 1'b0;
            dst_vec_q <= 1'b0;
        end else if (accept) begin
            cfg_q     <= '{m_any: m_any, fmsk: fmsk, fmap: fmap};
            code_q    <= pack_code_e'(pack_code);
            cf_base_q <= cf_base;
            rf_base_q <= rf_base;
            src_vec_q <= src_vec;
            dst_vec_q <= dst_vec;
        end
    end

    assign cf_rd_idx = src_vec_q ? (cf_base_q + CFI_W'(elem)) : cf_base_q;

    pbp_seq #(.VL_W(VL_W), .XLEN(XLEN)) u_seq (
        .clk(clk), .rst(rst), .start(start), .vl(vl),
        .dst_vec(dst_vec), .mapreduce(mapreduce),
        .accept(accept), .busy(busy), .elem(elem),
        .done(done), .err(err)
    );

    pbp_elem_test u_test (
        .cfg(cfg_q), .fld(cf_rd_data), .hit(hit)
    );

    pbp_pack #(.VL_W(VL_W), .XLEN(XLEN), .RFI_W(RFI_W)) u_pack (
        .clk(clk), .rst(rst), .valid(busy), .elem(elem),
        .dst_vec(dst_vec_q), .code(code_q), .rf_base(rf_base_q),
        .result(hit), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_mask(wr_mask), .wr_data(wr_data)
    );

    assert_no_write_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !done);

    assert_scalar_field_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && !src_vec_q) |-> $stable(cf_rd_idx));

endmodule

// File: tb/test_pred_bit_packer.sv
module test_pred_bit_packer;
    localparam int VL_W = 8, XLEN = 64, CFI_W = 7, RFI_W = 7;
    localparam int NCF = 1 << CFI_W, NRF = 1 << RFI_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [VL_W-1:0] vl = '0;
    logic src_vec = 1'b0, dst_vec = 1'b0, m_any = 1'b0, mapreduce = 1'b0;
    logic [CFI_W-1:0] cf_base = '0;
    logic [RFI_W-1:0] rf_base = '0;
    logic [3:0] fmsk = '0, fmap = '0;
    logic [1:0] pack_code = '0;
    logic [CFI_W-1:0] cf_rd_idx;
    logic [3:0] cf_rd_data;
    logic wr_en, done, err;
    logic [RFI_W-1:0] wr_idx;
    logic [XLEN-1:0] wr_mask, wr_data;

    logic [3:0]      cr_mem  [NCF];
    logic [XLEN-1:0] gpr_dut [NRF];
    logic [XLEN-1:0] gpr_exp [NRF];

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    assign cf_rd_data = cr_mem[cf_rd_idx];

    always @(posedge clk)
        if (wr_en) gpr_dut[wr_idx] <= (gpr_dut[wr_idx] & ~wr_mask) | (wr_data & wr_mask);

    pred_bit_packer #(.VL_W(VL_W), .XLEN(XLEN), .CFI_W(CFI_W), .RFI_W(RFI_W)) i_pred_bit_packer (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .src_vec(src_vec),
        .dst_vec(dst_vec), .cf_base(cf_base), .rf_base(rf_base), .m_any(m_any),
        .fmsk(fmsk), .fmap(fmap), .pack_code(pack_code), .mapreduce(mapreduce),
        .cf_rd_idx(cf_rd_idx), .cf_rd_data(cf_rd_data), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_data(wr_data), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // R2 reference: count masked bits whose value matches the map bit
    function automatic bit ref_bit(bit m, logic [3:0] msk, logic [3:0] map, logic [3:0] f);
        int want = 0, hits = 0;
        for (int b = 0; b < 4; b++)
            if (msk[b]) begin
                want++;
                if (f[b] == map[b]) hits++;
            end
        return m ? (hits > 0) : (hits == want);
    endfunction

    task automatic run_op(input int n_vl, input bit sv, input bit dv, input int cb, input int rb,
                          input bit m, input logic [3:0] msk, input logic [3:0] map,
                          input int code, input bit mr, input int restart_at);
        int q_f[$], q_idx[$];
        logic [63:0] q_mask[$], q_data[$];
        int k, n, bad;
        k = 1 << code;
        n = dv ? n_vl : (mr ? (n_vl > 64 ? 64 : n_vl) : (n_vl > 0 ? 1 : 0));
        bad = (!dv && n_vl > 64) ? 1 : 0;
        for (int i = 0; i < n; i++) begin
            int f, ri, p;
            bit r;
            f = sv ? (cb + i) % NCF : cb;
            r = ref_bit(m, msk, map, cr_mem[f]);
            if (dv) begin
                ri = (rb + i / k) % NRF;
                p  = i % k;
                if (p == 0) gpr_exp[ri] = '0;
                q_mask.push_back(p == 0 ? '1 : (64'd1 << p));
            end else begin
                ri = rb;
                p  = i;
                q_mask.push_back(64'd1 << p);
            end
            gpr_exp[ri][p] = r;
            q_f.push_back(f);
            q_idx.push_back(ri);
            q_data.push_back(64'(r) << p);
        end
        @(negedge clk);
        vl = VL_W'(n_vl); src_vec = sv; dst_vec = dv; cf_base = CFI_W'(cb); rf_base = RFI_W'(rb);
        m_any = m; fmsk = msk; fmap = map; pack_code = 2'(code); mapreduce = mr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < n; j++) begin
            chk(wr_en === 1'b1 && done === 1'b0, "R8 write strobe", {62'd0, wr_en, done}, 64'd2);
            chk(cf_rd_idx === CFI_W'(q_f[j]), "R1/R11 field index", 64'(cf_rd_idx), 64'(q_f[j]));
            chk(wr_idx === RFI_W'(q_idx[j]), dv ? "R3/R11 reg index" : "R5 reg index", 64'(wr_idx), 64'(q_idx[j]));
            chk(wr_mask === q_mask[j], dv ? "R4 mask" : "R5 mask", wr_mask, q_mask[j]);
            chk(wr_data === q_data[j], "R2 data", wr_data, q_data[j]);
            if (j == restart_at) start = 1'b1;   // R10 stimulus
            @(negedge clk);
            start = 1'b0;
        end
        chk(done === 1'b1 && wr_en === 1'b0, n == 0 ? "R9 done" : "R8 done", {62'd0, done, wr_en}, 64'd2);
        chk(err === 1'(bad), "R7 err", 64'(err), 64'(bad));
        @(negedge clk);
        chk(done === 1'b0 && wr_en === 1'b0 && err === 1'b0,
            restart_at >= 0 ? "R10 idle after" : "R8 done pulse", {61'd0, done, wr_en, err}, 64'd0);
        begin
            int mism = 0;
            for (int r = 0; r < NRF; r++) if (gpr_dut[r] !== gpr_exp[r]) mism++;
            chk(mism == 0, dv ? "R3/R4 register file" : "R5/R6 register file", 64'(mism), 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCF; i++) cr_mem[i] = 4'((i * 7 + 3) ^ (i >> 3));
        for (int i = 0; i < NRF; i++) begin
            gpr_dut[i] = {32'hA5A5_5A5A, 32'(i * 32'h0101_0101)};
            gpr_exp[i] = gpr_dut[i];
        end
        repeat (3) @(negedge clk);
        chk(wr_en === 1'b0 && done === 1'b0 && err === 1'b0, "R12 reset",
            {61'd0, wr_en, done, err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_en === 1'b0 && done === 1'b0, "R12 idle", {62'd0, wr_en, done}, 64'd0);
        // R3 one per register, any-test (R2)
        run_op(5, 1, 1, 3, 10, 1, 4'b0110, 4'b0010, 0, 0, -1);
        // R3 two per register, all-test
        run_op(7, 1, 1, 20, 20, 0, 4'b1011, 4'b1001, 1, 0, -1);
        // R3 four per register
        run_op(9, 1, 1, 40, 30, 1, 4'b1111, 4'b0000, 2, 0, -1);
        // R1 scalar source, R3 eight per register
        run_op(20, 0, 1, 17, 40, 0, 4'b0101, 4'b0100, 3, 0, -1);
        // R2 empty mask: all-test true, any-test false
        run_op(4, 1, 1, 50, 50, 0, 4'b0000, 4'b1010, 3, 0, -1);
        run_op(4, 1, 1, 50, 51, 1, 4'b0000, 4'b1010, 3, 0, -1);
        // R6 scalar destination without map-reduce
        run_op(10, 1, 0, 60, 60, 1, 4'b0011, 4'b0001, 0, 0, -1);
        // R5 R6 scalar destination with map-reduce
        run_op(40, 1, 0, 70, 61, 1, 4'b1100, 4'b0100, 0, 1, -1);
        // R7 scalar destination beyond 64 elements
        run_op(70, 1, 0, 5, 62, 0, 4'b1001, 4'b1000, 0, 1, -1);
        // R9 zero elements
        run_op(0, 1, 1, 0, 70, 1, 4'b1111, 4'b1111, 0, 0, -1);
        // R11 wrap of field and register indices
        run_op(12, 1, 1, 124, 126, 1, 4'b0111, 4'b0101, 2, 0, -1);
        // R10 start while busy
        run_op(8, 1, 1, 90, 80, 0, 4'b0001, 4'b0001, 1, 0, 2);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule